// File: doc/BRIEF.md
# Handshake Completion Flag Register

This block sits on the slave side of a mailbox that moves blocks of data between a host and a slave processor. The host signals progress through four handshake lines. The block watches them and keeps three sticky status flags. The first flag records that the host withdrew its event-attention request. The second records that the host finished reading a block. The third records that the host finished writing a block. The slave firmware reads these flags through a small register port. It clears a flag only by reading it as 1 and then writing 0 to it, so a host edge that lands between the read and the write is never lost.

Each flag has its own enable bit, and one shared enable gates a combined interrupt level to the slave CPU. A mode input picks which host line marks the end of a host read: either the buffer-to-host attention line or the host-busy line. Every handshake input passes through a synchronizer, and the flags react to falling edges only.

Top module: `attn_status_reg`

## Requirements
- R1: After reset, all three flags are 0, the register reads 0x00 and `irq_o` is 0.
- R2: Register bit 4 holds the event flag, bit 3 the read-complete flag and bit 2 the write-complete flag. Bits 7:5 and 1:0 always read 0.
- R3: A falling edge on `evt_attn_i` sets bit 4, and the set shows on `reg_rdata` at the third rising clock edge after the edge. A rising edge sets nothing.
- R4: A falling edge on `h2b_attn_i` sets bit 2.
- R5: With `rd_src_sel_i` = 0, a falling edge on `b2h_attn_i` sets bit 3, and edges on `h_busy_i` are ignored.
- R6: With `rd_src_sel_i` = 1, a falling edge on `h_busy_i` sets bit 3, and edges on `b2h_attn_i` are ignored.
- R7: A write of 0 to a flag bit clears that flag only if a read strobe saw the flag as 1 since the flag was last set or cleared. Without that read, the flag keeps its value.
- R8: Writing 1 to a flag bit has no effect. A write clears only the armed flags whose bits carry 0.
- R9: If a setting edge and a valid clear reach a flag in the same cycle, the flag stays 1.
- R10: A new setting event disarms the flag, so a later write of 0 without a fresh read leaves the flag at 1.
- R11: `irq_o` is 1 exactly when `irq_en_i` is 1 and some flag is 1 whose bit in `flag_en_i` is 1. The bits of `flag_en_i` are: bit 0 write-complete, bit 1 read-complete, bit 2 event. `irq_o` stays high as long as that condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_rd_i | input | 1 | Read strobe; arms every flag that reads as 1 |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Register contents (combinational) |
| evt_attn_i | input | 1 | Host event-attention line |
| b2h_attn_i | input | 1 | Buffer-to-host attention line |
| h_busy_i | input | 1 | Host busy line |
| h2b_attn_i | input | 1 | Host-to-buffer attention line |
| rd_src_sel_i | input | 1 | 0: read completion from b2h_attn_i, 1: from h_busy_i |
| irq_en_i | input | 1 | Shared interrupt enable |
| flag_en_i | input | 3 | Per-flag enables: bit0 write, bit1 read, bit2 event |
| irq_o | output | 1 | Combined interrupt level |

## Verification
The bench times a host edge so that it lands in the same cycle as a valid clear. A design that let the clear win would drop a completion. The bench also writes 0 without a prior read, and again after a re-set that came between the read and the write. A design that ignored the arming rule would clear the flag in either case. The bench drives edges on the line the mode does not select. A mux placed wrongly would set the read-complete flag from the wrong line. It also sweeps every combination of flags and enables against the interrupt. Any mistake in the gating shows up as a wrong `irq_o` level.

// File: rtl/attn_pkg.sv
package attn_pkg;
   localparam int unsigned NFLAG   = 3;
   localparam int unsigned FIDX_WR = 0;
   localparam int unsigned FIDX_RD = 1;
   localparam int unsigned FIDX_EV = 2;
   localparam int unsigned NLINE   = 4;
   localparam int unsigned LIDX_EVT  = 0;
   localparam int unsigned LIDX_B2H  = 1;
   localparam int unsigned LIDX_BUSY = 2;
   localparam int unsigned LIDX_H2B  = 3;
endpackage

// File: rtl/attn_edge_sync.sv
module attn_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic fall_o
);
   localparam int unsigned DEPTH = STAGES + 1;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("attn_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [DEPTH-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[DEPTH-2:0], line_i};
   end

   assign fall_o = pipe_q[DEPTH-1] & ~pipe_q[DEPTH-2];

   // R3: one edge yields a single-cycle pulse
   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);
endmodule

// File: rtl/attn_flag_cell.sv
module attn_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wbit_i,
   output logic flag_o
);
   logic flag_q, armed_q, clr;

   assign clr = wr_i & ~wbit_i & armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (set_i)    flag_q <= 1'b1;
         else if (clr) flag_q <= 1'b0;

         if (set_i || clr)        armed_q <= 1'b0;
         else if (rd_i && flag_q) armed_q <= 1'b1;
      end
   end

   assign flag_o = flag_q;

   // R7: unarmed zero write keeps the flag
   a_r7_keep_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && wr_i && !wbit_i && !armed_q && !set_i) |=> flag_q);
   // R9: a set always wins
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q);
   // R10: the armed state only exists while the flag is up
   a_r10_arm_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> flag_q);
   // R8: a flag rises only through a set event
   a_r8_no_rise_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !set_i) |=> !flag_q);
endmodule

// File: rtl/attn_status_reg.sv
module attn_status_reg #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned EVT_POS     = 4,
   parameter int unsigned RDC_POS     = 3,
   parameter int unsigned WRC_POS     = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           reg_rd_i,
   input  logic                           reg_wr_i,
   input  logic [DATA_W-1:0]              reg_wdata_i,
   output logic [DATA_W-1:0]              reg_rdata_o,
   input  logic                           evt_attn_i,
   input  logic                           b2h_attn_i,
   input  logic                           h_busy_i,
   input  logic                           h2b_attn_i,
   input  logic                           rd_src_sel_i,
   input  logic                           irq_en_i,
   input  logic [attn_pkg::NFLAG-1:0]     flag_en_i,
   output logic                           irq_o
);
   import attn_pkg::*;

   localparam int unsigned POS_WR = WRC_POS;
   localparam int unsigned POS_RD = RDC_POS;
   localparam int unsigned POS_EV = EVT_POS;

   function automatic int unsigned pos_of(input int unsigned idx);
      case (idx)
         FIDX_WR: return POS_WR;
         FIDX_RD: return POS_RD;
         default: return POS_EV;
      endcase
   endfunction

   generate
      if (EVT_POS >= DATA_W || RDC_POS >= DATA_W || WRC_POS >= DATA_W) begin : g_bad_pos
         $error("attn_status_reg: flag position outside register");
      end
      if (EVT_POS == RDC_POS || EVT_POS == WRC_POS || RDC_POS == WRC_POS) begin : g_dup_pos
         $error("attn_status_reg: flag positions overlap");
      end
   endgenerate

   logic [NLINE-1:0] lines, falls;
   logic [NFLAG-1:0] set_vec, flags;

   assign lines[LIDX_EVT]  = evt_attn_i;
   assign lines[LIDX_B2H]  = b2h_attn_i;
   assign lines[LIDX_BUSY] = h_busy_i;
   assign lines[LIDX_H2B]  = h2b_attn_i;

   generate
      for (genvar l = 0; l < NLINE; l++) begin : g_sync
         attn_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (lines[l]),
            .fall_o (falls[l])
         );
      end
   endgenerate

   assign set_vec[FIDX_EV] = falls[LIDX_EVT];
   assign set_vec[FIDX_WR] = falls[LIDX_H2B];
   assign set_vec[FIDX_RD] = rd_src_sel_i ? falls[LIDX_BUSY] : falls[LIDX_B2H];

   generate
      for (genvar f = 0; f < NFLAG; f++) begin : g_flag
         attn_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[f]),
            .rd_i   (reg_rd_i),
            .wr_i   (reg_wr_i),
            .wbit_i (reg_wdata_i[pos_of(f)]),
            .flag_o (flags[f])
         );
      end
   endgenerate

   always_comb begin
      reg_rdata_o = '0;
      for (int unsigned f = 0; f < NFLAG; f++) reg_rdata_o[pos_of(f)] = flags[f];
   end

   assign irq_o = irq_en_i & (|(flags & flag_en_i));

   // R11: no request without the shared enable
   a_r11_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> irq_en_i);
   // R11: no request with all flags clear
   a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (reg_rdata_o != '0));
   // R5: in mode 0 a busy edge alone cannot raise the read flag
   a_r5_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_src_sel_i && !falls[LIDX_B2H] && !flags[FIDX_RD]) |=> !flags[FIDX_RD]);
endmodule

// File: tb/test_attn_status_reg.sv
module test_attn_status_reg;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd = 1'b0, wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic evt = 1'b1, b2h = 1'b1, busy = 1'b1, h2b = 1'b1;
   logic sel = 1'b0, ien = 1'b0;
   logic [2:0] fen = '0;
   logic irq;
   int checks = 0, fails = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   attn_status_reg i_attn_status_reg (
      .clk(clk), .rst_n(rst_n), .reg_rd_i(rd), .reg_wr_i(wr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .evt_attn_i(evt), .b2h_attn_i(b2h), .h_busy_i(busy), .h2b_attn_i(h2b),
      .rd_src_sel_i(sel), .irq_en_i(ien), .flag_en_i(fen), .irq_o(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // 0 evt, 1 b2h, 2 busy, 3 h2b
   task automatic drive_line(input int which, input logic v);
      case (which)
         0: evt = v;
         1: b2h = v;
         2: busy = v;
         default: h2b = v;
      endcase
   endtask

   task automatic pulse_line(input int which);
      @(negedge clk); drive_line(which, 1'b0);
      cyc(4);
      drive_line(which, 1'b1);
      cyc(4);
   endtask

   task automatic reg_read();
      @(negedge clk); rd = 1'b1;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic reg_write(input logic [7:0] d);
      @(negedge clk); wr = 1'b1; wdata = d;
      @(negedge clk); wr = 1'b0; wdata = '0;
   endtask

   task automatic clear_all();
      reg_read();
      reg_write(8'h00);
   endtask

   initial begin
      cyc(3);
      chk("R1 reset rdata", rdata, 8'h00);
      chk("R1 reset irq", {7'b0, irq}, 8'h00);
      rst_n = 1'b1;
      cyc(4);
      chk("R1 after release", rdata, 8'h00);

      // R3 latency: the flag appears on the third edge
      @(negedge clk); evt = 1'b0;
      cyc(2);
      chk("R3 not yet", rdata, 8'h00);
      cyc(1);
      chk("R3 event set", rdata, 8'h10);
      cyc(2); evt = 1'b1; cyc(4);
      chk("R3 rise no effect", rdata, 8'h10);

      pulse_line(3);
      chk("R4 write-complete", rdata, 8'h14);
      sel = 1'b0;
      pulse_line(2);
      chk("R5 busy ignored", rdata, 8'h14);
      pulse_line(1);
      chk("R5 b2h sets", rdata, 8'h1C);

      reg_write(8'hFF);
      chk("R8 write ones", rdata, 8'h1C);
      reg_write(8'h00);
      chk("R7 unarmed zero", rdata, 8'h1C);
      reg_read();
      reg_write(8'hEF);
      chk("R8 selective clear", rdata, 8'h0C);
      reg_read();
      reg_write(8'h00);
      chk("R7 armed clear", rdata, 8'h00);

      sel = 1'b1;
      pulse_line(1);
      chk("R6 b2h ignored", rdata, 8'h00);
      pulse_line(2);
      chk("R6 busy sets", rdata, 8'h08);

      // R9: set and clear meet in the same cycle
      reg_read();
      @(negedge clk); busy = 1'b0;
      cyc(2);
      wr = 1'b1; wdata = 8'h00;
      @(negedge clk); wr = 1'b0;
      chk("R9 set beats clear", rdata, 8'h08);
      cyc(2); busy = 1'b1; cyc(4);
      reg_write(8'h00);
      chk("R10 disarmed after set", rdata, 8'h08);
      // R10: a re-set between read and write disarms
      reg_read();
      pulse_line(2);
      reg_write(8'h00);
      chk("R10 re-set disarms", rdata, 8'h08);
      clear_all();
      chk("R7 final clear", rdata, 8'h00);

      // R11 / R2 sweep over every flag subset and enable pattern
      for (int f = 0; f < 8; f++) begin
         clear_all();
         if (f[0]) pulse_line(3);
         if (f[1]) pulse_line(2);
         if (f[2]) pulse_line(0);
         chk("R2 layout", rdata, 8'(f << 2));
         for (int m = 0; m < 16; m++) begin
            @(negedge clk); ien = m[3]; fen = m[2:0];
            cyc(1);
            chk("R11 irq", {7'b0, irq}, {7'b0, m[3] & (|(f[2:0] & m[2:0]))});
         end
         ien = 1'b0; fen = '0;
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule